// File: doc/BRIEF.md
# Charge-Pump Pulse-Width Lock Detector

This block watches the up and down correction pulses that a phase-frequency detector sends to its charge pump. It runs on the reference clock and samples both pulse lines on every rising edge. A pulse that is still high on two consecutive edges is longer than one reference period and counts as a fault. A one-cycle strobe marks the end of each phase-comparison period. At each strobe the block judges the period that just ended. When a fault appeared anywhere in that period, the period is bad. Otherwise it is good, and a period with no pulse at all is also good.

The lock flag rises only after a fixed run of consecutive good periods. The default run is 15 periods. A single over-long pulse drops the flag on the very edge that detects it, without waiting for the strobe. The flag is a registered logic level, so no downstream comparator or filter is needed. The flag is a fault indicator rather than a true frequency-lock measurement. A period may be any number of reference cycles long, for example 65 cycles when a 13 MHz reference serves a 200 kHz comparison rate.

Top module: `pld_lock_detector`

## Requirements
- R1: While reset is low, and right after it is released, `lock_o` is 0. Reset also clears the run count and the per-period fault memory, and it acts asynchronously on the flag.
- R2: Pulse qualification works on each line separately. A line seen high on a single rising edge is short. A line seen high on two consecutive rising edges is too long. An up pulse followed at once by a down pulse is not a fault.
- R3: `lock_o` becomes 1 on the clock edge that samples the strobe closing the 15th consecutive good period. This holds for periods of any length, including 65 cycles and 1 cycle.
- R4: A too-long pulse drives `lock_o` to 0 on the same edge that sees it high for the second time, without waiting for a strobe. It also restarts the run of good periods from zero.
- R5: A period that held a too-long pulse anywhere counts as bad at its strobe, and 15 further good periods are needed before lock.
- R6: Once locked, further good periods keep `lock_o` at 1 indefinitely, and the run count saturates instead of wrapping.
- R7: A period with neither an up pulse nor a down pulse counts as good.
- R8: When a too-long pulse is detected in the strobe cycle of what would be the 15th good period, the clear wins: `lock_o` stays 0 and the run restarts.
- R9: A pulse that is high on a strobe edge and also on the following edge is a fault of the new period. It clears `lock_o` immediately and makes the new period bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_i | input | 1 | Up correction pulse from the phase detector |
| dn_i | input | 1 | Down correction pulse from the phase detector |
| cmp_strobe_i | input | 1 | One-cycle marker of the last cycle of a comparison period |
| lock_o | output | 1 | Registered lock flag |

## Verification
Two functions can meet in one cycle: the lock-assert decision made at a strobe and the immediate clear caused by a too-long pulse. The bench provokes this by running 14 good periods and then holding a down pulse high on the cycle before the strobe and on the strobe cycle itself. The expected result is that the flag stays low and a fresh run of 15 good periods is needed (R8). A second collision places a pulse across the strobe boundary after lock, and the flag must drop on the edge after the strobe (R9). A scoreboard compares the flag against a requirement-level model on every cycle.

// File: rtl/pld_pkg.sv
package pld_pkg;

  // Outcome of a comparison period, produced in the strobe cycle only.
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_GOOD = 2'd1,
    VERDICT_BAD  = 2'd2
  } verdict_e;

  // Correction pulse lines watched by the detector.
  localparam int unsigned PULSE_CH = 2;
  localparam int unsigned CH_UP    = 0;
  localparam int unsigned CH_DN    = 1;

endpackage

// File: rtl/pld_reset_sync.sv
module pld_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pld_pulse_qualifier.sv
module pld_pulse_qualifier
  import pld_pkg::*;
#(
  parameter int unsigned NUM_CH = PULSE_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic              strobe_i,
  output logic              long_now_o,
  output verdict_e          verdict_o
);

  logic [NUM_CH-1:0] seen_q;
  logic [NUM_CH-1:0] long_vec;
  logic              bad_seen_q;
  logic              bad_seen_d;

  // One previous-edge sample per line; a line is too long when high twice in a row.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen_q[c] <= 1'b0;
      end else begin
        seen_q[c] <= pulse_i[c];
      end
    end
    assign long_vec[c] = pulse_i[c] & seen_q[c];
  end

  assign long_now_o = |long_vec;

  always_comb begin
    verdict_o  = VERDICT_NONE;
    bad_seen_d = bad_seen_q | long_now_o;
    if (strobe_i) begin
      verdict_o  = (bad_seen_q | long_now_o) ? VERDICT_BAD : VERDICT_GOOD;
      bad_seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_seen_q <= 1'b0;
    end else begin
      bad_seen_q <= bad_seen_d;
    end
  end

  // R2: a line high on two consecutive edges must raise the fault
  assert_two_edges_long_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i[0] && $past(pulse_i[0])) |-> long_now_o);

  // R5: the fault memory starts each new period empty
  assert_sticky_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !bad_seen_q);

  // R5: a fault earlier in the period makes its verdict bad
  assert_fault_remembered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_now_o && !strobe_i) |=> (strobe_i |-> verdict_o == VERDICT_BAD));

endmodule

// File: rtl/pld_good_counter.sv
module pld_good_counter
  import pld_pkg::*;
#(
  parameter int unsigned TARGET = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  verdict_e verdict_i,
  input  logic     long_now_i,
  output logic     reached_o
);

  localparam int unsigned     CNT_W   = $clog2(TARGET + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TARGET);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             clr;

  always_comb begin
    clr    = long_now_i | (verdict_i == VERDICT_BAD);
    cnt_en = clr | (verdict_i == VERDICT_GOOD);
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
    reached_o = !long_now_i && (verdict_i == VERDICT_GOOD) && (cnt_q >= CNT_MAX - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: a full count never wraps while periods stay good
  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  // R4: a too-long pulse restarts the run
  assert_restart_on_long_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_now_i |=> cnt_q == '0);

endmodule

// File: rtl/pld_lock_detector.sv
module pld_lock_detector
  import pld_pkg::*;
#(
  parameter int unsigned GOOD_PERIODS = 15,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic cmp_strobe_i,
  output logic lock_o
);

  logic                rst_n;
  logic [PULSE_CH-1:0] pulses;
  logic                long_now;
  verdict_e            verdict;
  logic                reached;
  logic                lock_q;
  logic                lock_d;
  logic                lock_en;

  pld_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    pulses        = '0;
    pulses[CH_UP] = up_i;
    pulses[CH_DN] = dn_i;
  end

  pld_pulse_qualifier #(.NUM_CH(PULSE_CH)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .pulse_i    (pulses),
    .strobe_i   (cmp_strobe_i),
    .long_now_o (long_now),
    .verdict_o  (verdict)
  );

  pld_good_counter #(.TARGET(GOOD_PERIODS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .verdict_i  (verdict),
    .long_now_i (long_now),
    .reached_o  (reached)
  );

  // The flag changes only at a strobe or on a fault; a fault or bad verdict forces 0.
  always_comb begin
    lock_en = long_now | (verdict != VERDICT_NONE);
    lock_d  = reached;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  // R4: a detected fault drops the flag on that edge
  assert_clear_on_long_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    long_now |=> !lock_o);

  // R3: the flag rises only after a good strobe
  assert_rise_at_good_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_o) |-> $past(verdict == VERDICT_GOOD));

  // R6: without a strobe or fault the flag holds
  assert_flag_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cmp_strobe_i && !long_now) |=> $stable(lock_o));

endmodule

// File: tb/pld_lock_detector_bench.sv
module pld_lock_detector_bench;

  typedef struct {
    int    stamp;
    bit    exp;
    string tag;
  } item_t;

  logic clk;
  logic rst_ni;
  logic up_i, dn_i, cmp_strobe_i;
  logic lock_o;

  int cyc;
  int checks;
  int errors;
  item_t q[$];

  // bench-side model state
  bit m_pu, m_pd, m_bad, m_lock;
  int m_cnt;

  pld_lock_detector u_pld_lock_detector (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .up_i         (up_i),
    .dn_i         (dn_i),
    .cmp_strobe_i (cmp_strobe_i),
    .lock_o       (lock_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lock_o=%0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare every due expectation after the edge that produced it
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      item_t it;
      it = q.pop_front();
      check(lock_o, it.exp, it.tag);
    end
  end

  task automatic model_reset();
    m_pu = 0; m_pd = 0; m_bad = 0; m_lock = 0; m_cnt = 0;
  endtask

  // driver: one cycle of stimulus, plus the expected flag after its edge
  task automatic drive(input bit u, input bit d, input bit stb, input string tag);
    bit lng;
    item_t it;
    @(negedge clk);
    up_i = u; dn_i = d; cmp_strobe_i = stb;
    lng = (u && m_pu) || (d && m_pd);
    m_pu = u; m_pd = d;
    if (lng) begin
      m_lock = 0; m_cnt = 0; m_bad = !stb;
    end else if (stb) begin
      if (m_bad) begin
        m_cnt = 0; m_lock = 0;
      end else begin
        if (m_cnt < 15) m_cnt++;
        if (m_cnt == 15) m_lock = 1;
      end
      m_bad = 0;
    end
    it.stamp = cyc + 1;
    it.exp   = m_lock;
    it.tag   = tag;
    q.push_back(it);
  endtask

  // a period of len cycles; pulses start at *_at (negative = none) for *_len cycles
  task automatic period(input int len, input int up_at, input int up_len,
                        input int dn_at, input int dn_len, input string tag);
    for (int i = 0; i < len; i++) begin
      bit u, d;
      u = (up_at >= 0) && (i >= up_at) && (i < up_at + up_len);
      d = (dn_at >= 0) && (i >= dn_at) && (i < dn_at + dn_len);
      drive(u, d, i == len - 1, tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; up_i = 0; dn_i = 0; cmp_strobe_i = 0;
    #1;
    check(lock_o, 1'b0, "R1 flag low in reset");
    repeat (3) @(negedge clk);
    check(lock_o, 1'b0, "R1 flag low held in reset");
    rst_ni = 1'b1;
    model_reset();
    for (int i = 0; i < 4; i++) drive(0, 0, 0, "R1 idle after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    up_i = 0; dn_i = 0; cmp_strobe_i = 0;
    cyc = 0; checks = 0; errors = 0;
    model_reset();
    do_reset();

    // R3: 15 good 65-cycle periods with short pulses
    for (int p = 0; p < 15; p++) period(65, 10, 1, 30, 1, "R3 lock after 15 good periods");

    // R6 and R7: more good and empty periods keep lock, no wrap
    for (int p = 0; p < 20; p++) period(65, 5, 1, -1, 0, "R6 lock held past saturation");
    for (int p = 0; p < 4; p++)  period(65, -1, 0, -1, 0, "R7 empty period stays locked");

    // R4: long up pulse mid-period clears at once
    period(65, 20, 3, -1, 0, "R4 long up clears immediately");
    // R5: 14 good then not yet locked; the 15th locks. R2: up then down adjacent is short
    for (int p = 0; p < 14; p++) period(65, 40, 1, 41, 1, "R2 adjacent up/down is short");
    period(65, 40, 1, 41, 1, "R5 relock needs 15 good periods");

    // R4 on down line, then R7 empty periods rebuild lock
    period(65, -1, 0, 12, 2, "R4 long down clears immediately");
    for (int p = 0; p < 15; p++) period(65, -1, 0, -1, 0, "R7 empty periods count as good");

    // R8: collision, fault detected in the strobe cycle of the 15th period
    period(65, -1, 0, 7, 2, "R8 setup clear");
    for (int p = 0; p < 14; p++) period(65, 3, 1, -1, 0, "R8 run of 14");
    period(65, -1, 0, 63, 2, "R8 fault on strobe beats lock");
    for (int p = 0; p < 15; p++) period(65, 3, 1, -1, 0, "R8 fresh run needed");

    // R9: pulse spanning the strobe boundary
    for (int i = 0; i < 9; i++) drive(0, 0, 0, "R9 lead-in");
    drive(1, 0, 1, "R9 high on strobe edge");
    drive(1, 0, 0, "R9 second edge clears");
    for (int i = 0; i < 9; i++) drive(0, 0, 0, "R9 period body");
    drive(0, 0, 1, "R9 new period judged bad");

    // R3: one-cycle periods
    for (int p = 0; p < 15; p++) drive(0, 0, 1, "R3 one-cycle periods lock");

    // R1: reset while locked
    repeat (3) @(negedge clk);
    do_reset();
    period(65, -1, 0, -1, 0, "R1 single good period after reset");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule